// File: doc/BRIEF.md
# Multi-Channel Match PWM Generator

This block produces a bank of pulse-width-modulated outputs from a single free-running tick counter. A programmable prescaler divides the clock into counter ticks. The counter is compared against seven match values. Match value 0 fixes the shared cycle length. Each of the other six match values shapes one output. An output in single-edge mode rises when a new cycle begins and falls at its own match. An output in double-edge mode rises at the match of the channel below it and falls at its own match. This mode gives positive or negative pulses, depending on which of the two match values is smaller.

Each match value also carries three optional actions: flag an interrupt, restart the count, or halt the counter. Software writes new match values at any time. While the counter runs, new values wait in a holding copy and take effect together at the next cycle start, so edges within one cycle always come from one consistent set.

Register map (address on `wr_addr`, data on `wr_data`): 0..6 are match values 0..6. 8 is the run control (bit 0 run, bit 1 hold-clear). 9 is the prescale value P. 10 holds the match actions: bit 3k is the interrupt enable of match k, bit 3k+1 is its restart enable and bit 3k+2 is its halt enable. 11 is the edge mode, where bit n set makes channel n double-edge (n = 2..6). 12 is the interrupt clear, which is write-1-to-clear.

Top module: `pwm_match_top`

## Requirements
- R1: After reset, every bit of `pwm_out` and `irq_flags` is 0.
- R2: While running with prescale P, the counter advances once every P+1 clocks through the values 0..M0 and then restarts at 0. One cycle is therefore (M0+1)(P+1) clocks, and every output repeats at that rate.
- R3: A single-edge channel n (whose output is `pwm_out[n-1]`) with Mn < M0 rises at each cycle start and stays high while the count is in 0..Mn. That is Mn+1 ticks per cycle.
- R4: A single-edge channel with Mn >= M0 stays constantly low.
- R5: A double-edge channel n (mode bit n = 1) is high while the count lies after M(n-1) up to and including Mn. When M(n-1) < Mn this is a positive pulse of Mn-M(n-1) ticks. When M(n-1) > Mn it is a negative-going pulse, high for (M0+1)-(M(n-1)-Mn) ticks.
- R6: When a channel's set and clear fall on the same tick, the clear wins. A double-edge channel with M(n-1) = Mn therefore stays low.
- R7: A match on k with interrupt enable (bit 3k of address 10) sets `irq_flags[k]`. The flag stays set until a write to address 12 with bit k = 1. A write with bit k = 0 leaves the flag unchanged.
- R8: A match on k >= 1 with restart enable (bit 3k+1) returns the count to 0 without starting a new cycle. Single-edge outputs are then never set.
- R9: A match on k with halt enable (bit 3k+2) freezes the counter and clears the run bit, so the outputs hold. Writing run = 1 resumes counting.
- R10: Match values written while running take effect only at the next cycle start. While halted they take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 21 | Register write data |
| pwm_out | output | 6 | Channel outputs, bit n-1 is channel n |
| irq_flags | output | 7 | Sticky match flags, bit k for match k |

## Verification
A corrupted counter or a wrong active match value shows up within one cycle as a changed high-time or a changed rise spacing on the outputs. For this reason, duty is measured over whole cycles and rises are counted over several cycles. A bad holding-copy transfer shows only at the cycle boundary after the write, so pulse lengths are taken on both sides of that boundary. A lost halt or restart action changes output activity within the next cycle.

// File: rtl/pwm_match_pkg.sv
`timescale 1ns/1ps
package pwm_match_pkg;
    typedef struct packed {
        logic stop;
        logic rst;
        logic irq;
    } match_act_t;

    localparam int unsigned ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd8;
    localparam logic [ADDR_W-1:0] A_PRESC  = 4'd9;
    localparam logic [ADDR_W-1:0] A_ACT    = 4'd10;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'd11;
    localparam logic [ADDR_W-1:0] A_IRQCLR = 4'd12;
endpackage

// File: rtl/pwm_match_regs.sv
`timescale 1ns/1ps
module pwm_match_regs
    import pwm_match_pkg::*;
#(
    parameter int unsigned CW = 16,
    parameter int unsigned NM = 7,
    parameter int unsigned PW = 8,
    parameter int unsigned DW = 21
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [NM-1:0]          match,
    input  logic                   stop_hit,
    output logic [NM-1:0][CW-1:0]  shadow,
    output match_act_t [NM-1:0]    act,
    output logic [NM-1:2]          dbl,
    output logic [PW-1:0]          presc,
    output logic                   run,
    output logic                   clr,
    output logic [NM-1:0]          irq
);
    typedef struct packed {
        logic [NM-1:0][CW-1:0] sh;
        match_act_t [NM-1:0]   act;
        logic [NM-1:2]         dbl;
        logic [PW-1:0]         presc;
        logic                  run;
        logic                  clr;
        logic [NM-1:0]         irq;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic [NM-1:0] clr_mask;
    logic [NM-1:0] set_mask;

    always_comb begin
        s_d      = s_q;
        clr_mask = '0;
        set_mask = '0;
        if (wr_en) begin
            for (int k = 0; k < NM; k++) begin
                if (wr_addr == ADDR_W'(k)) s_d.sh[k] = wr_data[CW-1:0];
            end
            if (wr_addr == A_CTRL) begin
                s_d.run = wr_data[0];
                s_d.clr = wr_data[1];
            end
            if (wr_addr == A_PRESC) s_d.presc = wr_data[PW-1:0];
            if (wr_addr == A_ACT) begin
                for (int k = 0; k < NM; k++) s_d.act[k] = match_act_t'(wr_data[3*k +: 3]);
            end
            if (wr_addr == A_MODE)   s_d.dbl  = wr_data[NM-1:2];
            if (wr_addr == A_IRQCLR) clr_mask = wr_data[NM-1:0];
        end
        if (stop_hit) s_d.run = 1'b0;
        for (int k = 0; k < NM; k++) set_mask[k] = match[k] & s_q.act[k].irq;
        s_d.irq = (s_q.irq & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shadow = s_q.sh;
    assign act    = s_q.act;
    assign dbl    = s_q.dbl;
    assign presc  = s_q.presc;
    assign run    = s_q.run;
    assign clr    = s_q.clr;
    assign irq    = s_q.irq;
endmodule

// File: rtl/pwm_match_timer.sv
`timescale 1ns/1ps
module pwm_match_timer
    import pwm_match_pkg::*;
#(
    parameter int unsigned CW = 16,
    parameter int unsigned NM = 7,
    parameter int unsigned PW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   clr,
    input  logic [PW-1:0]          presc,
    input  logic [NM-1:0][CW-1:0]  shadow,
    input  match_act_t [NM-1:0]    act,
    output logic [NM-1:0]          match,
    output logic                   stop_hit,
    output logic                   restart,
    output logic [CW-1:0]          count
);
    typedef struct packed {
        logic [PW-1:0]         pc;
        logic [CW-1:0]         tc;
        logic [NM-1:0][CW-1:0] mr;
    } tmr_state_t;

    tmr_state_t s_d, s_q;
    logic          tick;
    logic [NM-1:0] rst_v;
    logic [NM-1:0] stop_v;

    always_comb begin
        tick = run && !clr && (s_q.pc == presc);
        for (int k = 0; k < NM; k++) begin
            match[k]  = tick && (s_q.tc == s_q.mr[k]);
            rst_v[k]  = match[k] & act[k].rst;
            stop_v[k] = match[k] & act[k].stop;
        end
        stop_hit = |stop_v;
        restart  = match[0] && !stop_hit;

        s_d = s_q;
        if (!run || clr || tick) s_d.pc = '0;
        else                     s_d.pc = s_q.pc + PW'(1);

        if (clr) begin
            s_d.tc = '0;
        end else if (tick && !stop_hit) begin
            if (match[0] || (|rst_v)) s_d.tc = '0;
            else                      s_d.tc = s_q.tc + CW'(1);
        end

        if (!run || restart) s_d.mr = shadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.tc;
endmodule

// File: rtl/pwm_match_chan.sv
`timescale 1ns/1ps
module pwm_match_chan #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbl,
    input  logic          restart,
    input  logic          set_m,
    input  logic          clr_m,
    input  logic [CW-1:0] sh_self,
    input  logic [CW-1:0] sh_period,
    output logic          pwm
);
    logic pwm_d, pwm_q;
    logic set_now;

    always_comb begin
        set_now = dbl ? set_m : (restart && (sh_self < sh_period));
        pwm_d   = pwm_q;
        if (clr_m)        pwm_d = 1'b0;
        else if (set_now) pwm_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    assign pwm = pwm_q;
endmodule

// File: rtl/pwm_match_top.sv
`timescale 1ns/1ps
module pwm_match_top
    import pwm_match_pkg::*;
#(
    parameter int unsigned CW = 16,
    parameter int unsigned NM = 7,
    parameter int unsigned PW = 8,
    parameter int unsigned DW = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NM-2:0]     pwm_out,
    output logic [NM-1:0]     irq_flags
);
    localparam int unsigned NCH = NM - 1;

    logic [NM-1:0][CW-1:0] shadow;
    match_act_t [NM-1:0]   act;
    logic [NM-1:2]         dbl;
    logic [PW-1:0]         presc;
    logic                  run;
    logic                  clr;
    logic [NM-1:0]         match;
    logic                  stop_hit;
    logic                  restart;
    logic [CW-1:0]         count;

    pwm_match_regs #(.CW(CW), .NM(NM), .PW(PW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .match(match), .stop_hit(stop_hit), .shadow(shadow), .act(act), .dbl(dbl),
        .presc(presc), .run(run), .clr(clr), .irq(irq_flags)
    );

    pwm_match_timer #(.CW(CW), .NM(NM), .PW(PW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .presc(presc), .shadow(shadow),
        .act(act), .match(match), .stop_hit(stop_hit), .restart(restart), .count(count)
    );

    for (genvar n = 1; n <= NCH; n++) begin : g_ch
        logic mode_dbl;
        if (n >= 2) begin : g_dbl
            assign mode_dbl = dbl[n];
        end else begin : g_single
            assign mode_dbl = 1'b0;
        end
        pwm_match_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .dbl(mode_dbl), .restart(restart),
            .set_m(match[n-1]), .clr_m(match[n]), .sh_self(shadow[n]),
            .sh_period(shadow[0]), .pwm(pwm_out[n-1])
        );
    end
endmodule

module pwm_match_chk
    import pwm_match_pkg::*;
#(
    parameter int unsigned CW = 16,
    parameter int unsigned NM = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NM-1:0]     wr_bits,
    input logic [NM-2:0]     pwm_out,
    input logic [NM-1:0]     irq_flags,
    input logic [NM-1:0]     match,
    input logic              restart,
    input logic              stop_hit,
    input logic              run,
    input logic [CW-1:0]     count
);
    logic [NM-1:0] keep;
    assign keep = irq_flags & ~((wr_en && wr_addr == A_IRQCLR) ? wr_bits : '0);

    assert_cycle_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));

    assert_edge_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out != $past(pwm_out)) |-> $past(|match));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pwm_out & $past(match[NM-1:1])) == '0));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_flags & $past(keep)) == $past(keep)));

    assert_halt_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> (!run && $stable(count)));
endmodule

bind pwm_match_top pwm_match_chk #(.CW(CW), .NM(NM)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bits(wr_data[NM-1:0]),
    .pwm_out(pwm_out), .irq_flags(irq_flags), .match(match), .restart(restart),
    .stop_hit(stop_hit), .run(run), .count(count)
);

// File: tb/pwm_match_top_tb_top.sv
`timescale 1ns/1ps
module pwm_match_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [20:0] wr_data = '0;
    logic [5:0]  pwm_out;
    logic [6:0]  irq_flags;

    int total = 0;
    int bad = 0;
    logic [15:0] mv [7];

    always #4 clk = ~clk;

    pwm_match_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .irq_flags(irq_flags)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [20:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [20:0] act, input logic [20:0] mode, input logic [20:0] pre);
        wr(4'd8, 21'd2);
        for (int k = 0; k < 7; k++) wr(4'(k), 21'(mv[k]));
        wr(4'd10, act);
        wr(4'd11, mode);
        wr(4'd9, pre);
        wr(4'd8, 21'd1);
    endtask

    task automatic count_high(input int ch, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) c++;
        end
    endtask

    task automatic count_rises(input int ch, input int n, output int c);
        logic prev;
        c = 0;
        prev = pwm_out[ch];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) c++;
            prev = pwm_out[ch];
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic test_reset();
        check("R1", "pwm_out after reset", int'(pwm_out), 0);
        check("R1", "irq_flags after reset", int'(irq_flags), 0);
    endtask

    task automatic test_single_and_double();
        int c;
        mv = '{16'd9, 16'd3, 16'd12, 16'd9, 16'd0, 16'd2, 16'd6};
        setup(21'd0, 21'(1 << 6), 21'd0);
        repeat (40) @(negedge clk);
        count_high(0, 10, c); check("R3", "ch1 high ticks M1=3", c, 4);
        count_high(3, 10, c); check("R3", "ch4 high ticks M4=0", c, 1);
        count_high(4, 10, c); check("R3", "ch5 high ticks M5=2", c, 3);
        count_high(1, 10, c); check("R4", "ch2 M2>M0 constant low", c, 0);
        count_high(2, 10, c); check("R4", "ch3 M3=M0 constant low", c, 0);
        count_high(5, 10, c); check("R5", "ch6 positive pulse", c, 4);
        count_rises(0, 30, c); check("R2", "ch1 rises in 3 cycles", c, 3);
    endtask

    task automatic test_prescale();
        int c;
        mv = '{16'd9, 16'd3, 16'd12, 16'd9, 16'd0, 16'd2, 16'd6};
        setup(21'd0, 21'(1 << 6), 21'd1);
        repeat (60) @(negedge clk);
        count_high(0, 20, c); check("R2", "ch1 high clocks prescale 1", c, 8);
        count_high(5, 20, c); check("R2", "ch6 high clocks prescale 1", c, 8);
        count_rises(0, 40, c); check("R2", "ch1 rises in 40 clocks", c, 2);
    endtask

    task automatic test_negative_and_priority();
        int c;
        mv = '{16'd9, 16'd12, 16'd6, 16'd2, 16'd4, 16'd4, 16'd12};
        setup(21'd0, 21'((1 << 3) | (1 << 5)), 21'd0);
        repeat (40) @(negedge clk);
        count_high(2, 10, c); check("R5", "ch3 negative pulse", c, 6);
        count_high(3, 10, c); check("R3", "ch4 single M4=4", c, 5);
        count_high(4, 10, c); check("R6", "ch5 equal set/clear low", c, 0);
    endtask

    task automatic test_irq();
        mv = '{16'd9, 16'd1, 16'd5, 16'd12, 16'd12, 16'd12, 16'd12};
        setup(21'(1 << 6), 21'd0, 21'd0);
        repeat (25) @(negedge clk);
        check("R7", "flag 2 set on match", int'(irq_flags), 4);
        repeat (13) @(negedge clk);
        check("R7", "flag 2 sticky", int'(irq_flags), 4);
        wr(4'd8, 21'd0);
        wr(4'd12, 21'd1);
        @(negedge clk);
        check("R7", "clear of other bit no effect", int'(irq_flags), 4);
        wr(4'd12, 21'd4);
        @(negedge clk);
        check("R7", "flag 2 cleared", int'(irq_flags), 0);
    endtask

    task automatic test_restart_match();
        int c;
        mv = '{16'd9, 16'd1, 16'd3, 16'd4, 16'd12, 16'd12, 16'd12};
        setup(21'(1 << 10), 21'(1 << 2), 21'd0);
        repeat (40) @(negedge clk);
        count_high(1, 10, c); check("R8", "ch2 under short restart", c, 4);
        count_rises(1, 20, c); check("R8", "ch2 rise spacing 5", c, 4);
        count_high(0, 10, c); check("R8", "ch1 never set", c, 0);
        count_high(2, 10, c); check("R8", "ch3 never set", c, 0);
    endtask

    task automatic test_halt();
        int c;
        mv = '{16'd9, 16'd4, 16'd6, 16'd12, 16'd12, 16'd12, 16'd12};
        setup(21'(1 << 5), 21'(1 << 2), 21'd0);
        repeat (20) @(negedge clk);
        count_high(1, 30, c); check("R9", "ch2 frozen high", c, 30);
        wr(4'd10, 21'd0);
        wr(4'd8, 21'd1);
        repeat (30) @(negedge clk);
        count_high(1, 10, c); check("R9", "ch2 after resume", c, 2);
    endtask

    task automatic test_shadow();
        int len;
        mv = '{16'd9, 16'd3, 16'd12, 16'd12, 16'd12, 16'd12, 16'd12};
        setup(21'd0, 21'd0, 21'd0);
        repeat (30) @(negedge clk);
        wait_rise(0);
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 21'd7;
        len = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (pwm_out[0]) begin
            len++;
            @(negedge clk);
        end
        check("R10", "pulse during write keeps old value", len, 4);
        wait_rise(0);
        len = 0;
        while (pwm_out[0]) begin
            len++;
            @(negedge clk);
        end
        check("R10", "next cycle uses new value", len, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_single_and_double();
        test_prescale();
        test_negative_and_priority();
        test_irq();
        test_restart_match();
        test_halt();
        test_shadow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule